// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block collects 32 level-sensitive device interrupt lines and software interrupt requests, and presents a 4-bit priority level to each processor in a small multiprocessor system. The processor count is a parameter. Every processor owns a software pending word. Software raises and drops interrupts in that word through write-one set and clear ports.

A system-wide mask filters the device lines. Writing 1 to the mask's disable port sets a mask bit, and writing 1 to its enable port clears one. The top mask bit silences every device line at once. The device lines that pass the mask are all routed to a single target processor, chosen by a readable and writable target register. Software reaches the registers over a single-cycle bus. Writes take effect at the clock edge, and read data is a combinational function of the address.

Top module: `mp_irq_top`

## Requirements
- R1: After reset the mask reads 0xFFFFFFFF, the target reads 0, every CPU pending word reads 0 and every CPU level output is 0.
- R2: CPU c occupies word addresses 4c to 4c+3. A write to 4c+2 sets software level x (1..15) of CPU c for each data bit 16+x written as 1. Zero bits change nothing. Address 4c reads the pending word, with software level x in bit 16+x. Bit 16 always reads 0.
- R3: A write to address 4c+1 clears software level x of CPU c for each data bit 16+x written as 1. Zero bits change nothing.
- R4: The system region starts at S = 4*NUM_CPU. S+1 reads the mask. A write to S+2 clears each mask bit written as 1, which enables that line. A write to S+3 sets each mask bit written as 1, which disables that line. Zero bits change nothing in either case.
- R5: While mask bit 31 is set, the system pending word reads 0 and no device line affects any CPU level.
- R6: While mask bit 31 is clear, the system pending word at S reads device lines AND NOT mask.
- R7: Address S+4 holds the target CPU index. It is readable and writable, and only its low clog2(NUM_CPU) bits are stored.
- R8: Only the CPU whose index equals the target sees device interrupts. In its pending word, bit L (1..15) is set when some system-pending line maps to level L. Every other CPU's low 16 pending bits read 0, and its level depends only on its software bits.
- R9: The device level map is as follows. Bits 28–30 map to 15. Bit 19 maps to 14. Bit 16 maps to 13. Bits 14, 15 and 18 map to 12. Bit 22 maps to 11. Bit 21 maps to 10. Bit 17 maps to 9. Bit 20 maps to 8. Expansion bit 7+k (k = 0..6) maps to level k+1. All other bits map to level 0, which means no interrupt.
- R10: Each CPU level output is the highest level among its set software levels and, for the target CPU, its routed device levels. It is 0 when none is set.
- R11: Reads of write-only ports (4c+1, 4c+2, S+2, S+3) and of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devIrq | input | 32 | Level-sensitive device interrupt lines |
| busAddr | input | ADDR_W | Word address |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| cpuLevel | output | 4*NUM_CPU | Priority level per CPU, CPU c in bits 4c+3:4c |

## Verification
The bench builds the block with its default values: four CPUs and a 6-bit address. This puts the system region at word 16, and every one of the four target values is legal. With four CPUs, a change of target can move device interrupts away from CPU 0 and onto a CPU whose software bits are also live. The check then shows that exactly one CPU receives the device levels. The 6-bit address also leaves unused words above the system region, so reads of unmapped space can be tested.

// File: rtl/mp_irq_pkg.sv
package mp_irq_pkg;
  localparam int WORD_W = 32;
  localparam int CPU_SEL_W = 4;
  localparam int LVL_W = 4;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CPU_PEND,
    RD_SYS_PEND,
    RD_SYS_MASK,
    RD_TARGET
  } rdSrc_e;

  typedef struct packed {
    logic softSet;
    logic softClr;
    logic maskSet;
    logic maskClr;
    logic tgtWr;
    logic [CPU_SEL_W-1:0] cpuSel;
    rdSrc_e rdSrc;
  } busStrobe_t;

  // Priority assigned to each device line.
  function automatic logic [LVL_W-1:0] devLevel(input int unsigned idx);
    logic [LVL_W-1:0] lv;
    lv = '0;
    if (idx >= 7 && idx <= 13) lv = LVL_W'(idx - 6);
    else begin
      case (idx)
        28, 29, 30: lv = 4'd15;
        19:         lv = 4'd14;
        16:         lv = 4'd13;
        14, 15, 18: lv = 4'd12;
        22:         lv = 4'd11;
        21:         lv = 4'd10;
        17:         lv = 4'd9;
        20:         lv = 4'd8;
        default:    lv = '0;
      endcase
    end
    return lv;
  endfunction

  // Index of the highest set bit among 1..15.
  function automatic logic [LVL_W-1:0] topLevel(input logic [15:1] vec);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int l = 1; l < 16; l++)
      if (vec[l]) r = LVL_W'(l);
    return r;
  endfunction
endpackage

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
  import mp_irq_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrobe_t        strobe
);
  localparam int SYS_BASE = NUM_CPU * 4;

  logic [ADDR_W-1:0] sysOff;
  assign sysOff = busAddr - ADDR_W'(SYS_BASE);

  always_comb begin
    strobe = '0;
    strobe.rdSrc = RD_ZERO;
    if (busAddr < ADDR_W'(SYS_BASE)) begin
      strobe.cpuSel = CPU_SEL_W'(busAddr >> 2);
      case (busAddr[1:0])
        2'd0:    strobe.rdSrc = RD_CPU_PEND;
        2'd1:    strobe.softClr = busWe;
        2'd2:    strobe.softSet = busWe;
        default: ;
      endcase
    end else begin
      case (sysOff)
        ADDR_W'(0): strobe.rdSrc = RD_SYS_PEND;
        ADDR_W'(1): strobe.rdSrc = RD_SYS_MASK;
        ADDR_W'(2): strobe.maskClr = busWe;
        ADDR_W'(3): strobe.maskSet = busWe;
        ADDR_W'(4): begin
          strobe.rdSrc = RD_TARGET;
          strobe.tgtWr = busWe;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mp_irq_dpath.sv
module mp_irq_dpath
  import mp_irq_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [WORD_W-1:0]        devIrq,
  input  busStrobe_t               strobe,
  input  logic [WORD_W-1:0]        wdata,
  output logic [WORD_W-1:0]        rdata,
  output logic [NUM_CPU*LVL_W-1:0] cpuLevel
);
  localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam int SOFT_W = 15;

  logic [WORD_W-1:0]         maskQ;
  logic [TGT_W-1:0]          targetQ;
  logic [WORD_W-1:0]         sysPend;
  logic [15:1]               hwHi;
  logic [WORD_W-1:0]         pendWord [NUM_CPU];
  logic [NUM_CPU*SOFT_W-1:0] softPendFlat;

  always_ff @(posedge clk) begin
    if (!rstN) maskQ <= '1;
    else if (strobe.maskSet) maskQ <= maskQ | wdata;
    else if (strobe.maskClr) maskQ <= maskQ & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) targetQ <= '0;
    else if (strobe.tgtWr) targetQ <= wdata[TGT_W-1:0];
  end

  assign sysPend = maskQ[WORD_W-1] ? '0 : (devIrq & ~maskQ);

  always_comb begin
    hwHi = '0;
    for (int l = 1; l < 16; l++)
      for (int i = 0; i < WORD_W; i++)
        if (sysPend[i] && devLevel(i) == LVL_W'(l)) hwHi[l] = 1'b1;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [15:1] softQ;
    logic [15:1] routed;
    logic        hit;

    assign hit = strobe.cpuSel == CPU_SEL_W'(c);

    always_ff @(posedge clk) begin
      if (!rstN) softQ <= '0;
      else if (strobe.softSet && hit) softQ <= softQ | wdata[31:17];
      else if (strobe.softClr && hit) softQ <= softQ & ~wdata[31:17];
    end

    assign routed = (targetQ == TGT_W'(c)) ? hwHi : '0;
    assign pendWord[c] = {softQ, 1'b0, routed, 1'b0};
    assign cpuLevel[c*LVL_W +: LVL_W] = topLevel(softQ | routed);
    assign softPendFlat[c*SOFT_W +: SOFT_W] = softQ;
  end

  always_comb begin
    rdata = '0;
    case (strobe.rdSrc)
      RD_CPU_PEND:
        for (int c = 0; c < NUM_CPU; c++)
          if (strobe.cpuSel == CPU_SEL_W'(c)) rdata = pendWord[c];
      RD_SYS_PEND: rdata = sysPend;
      RD_SYS_MASK: rdata = maskQ;
      RD_TARGET:   rdata = WORD_W'(targetQ);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/mp_irq_top.sv
module mp_irq_top
  import mp_irq_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [31:0]              devIrq,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWe,
  input  logic [31:0]              busWdata,
  output logic [31:0]              busRdata,
  output logic [NUM_CPU*4-1:0]     cpuLevel
);
  busStrobe_t strobe;

  mp_irq_ctrl #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strobe (strobe)
  );

  mp_irq_dpath #(.NUM_CPU(NUM_CPU)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .devIrq  (devIrq),
    .strobe  (strobe),
    .wdata   (busWdata),
    .rdata   (busRdata),
    .cpuLevel(cpuLevel)
  );
endmodule

// File: rtl/mp_irq_chk.sv
module mp_irq_chk #(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 6
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [31:0]              devIrq,
  input logic [ADDR_W-1:0]        busAddr,
  input logic                     busWe,
  input logic [31:0]              busWdata,
  input logic [NUM_CPU*4-1:0]     cpuLevel,
  input logic [NUM_CPU*15-1:0]    softPendFlat,
  input logic [31:0]              maskQ,
  input logic [((NUM_CPU > 1) ? $clog2(NUM_CPU) : 1)-1:0] targetQ
);
  localparam int SYS_BASE = NUM_CPU * 4;
  localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    // R2
    soft_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && busAddr == ADDR_W'(c*4+2)) |=>
      ((softPendFlat[c*15 +: 15] & $past(busWdata[31:17])) == $past(busWdata[31:17])));
    // R3
    soft_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && busAddr == ADDR_W'(c*4+1)) |=>
      ((softPendFlat[c*15 +: 15] & $past(busWdata[31:17])) == 15'd0));
    // R8
    non_target_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (targetQ != TGT_W'(c) && softPendFlat[c*15 +: 15] == 15'd0) |->
      (cpuLevel[c*4 +: 4] == 4'd0));
  end

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(SYS_BASE+3)) |=>
    ((maskQ & $past(busWdata)) == $past(busWdata)));
  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(SYS_BASE+2)) |=>
    ((maskQ & $past(busWdata)) == 32'd0));
  // R7
  target_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(SYS_BASE+4)) |=>
    (targetQ == $past(busWdata[TGT_W-1:0])));
  // R5
  mask_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[31] && softPendFlat == '0) |-> (cpuLevel == '0));
  // R10
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (softPendFlat == '0 && (devIrq & ~maskQ) == 32'd0) |-> (cpuLevel == '0));
endmodule

bind mp_irq_top mp_irq_chk #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .devIrq      (devIrq),
  .busAddr     (busAddr),
  .busWe       (busWe),
  .busWdata    (busWdata),
  .cpuLevel    (cpuLevel),
  .softPendFlat(u_dp.softPendFlat),
  .maskQ       (u_dp.maskQ),
  .targetQ     (u_dp.targetQ)
);

// File: tb/mp_irq_top_bench.sv
module mp_irq_top_bench;
  localparam int NC = 4;
  localparam int AW = 6;
  localparam int SYS = NC * 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [31:0]   devIrq = '0;
  logic [AW-1:0] busAddr = '0;
  logic          busWe = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NC*4-1:0] cpuLevel;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  logic [15:1] mSoft [NC];
  logic [31:0] mMask;
  logic [1:0]  mTgt;

  always #4 clk = ~clk;

  mp_irq_top #(.NUM_CPU(NC), .ADDR_W(AW)) u_mp_irq_top (
    .clk(clk), .rstN(rstN), .devIrq(devIrq), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .cpuLevel(cpuLevel)
  );

  // Level map taken from R9.
  function automatic logic [3:0] mLvl(input int i);
    if (i >= 7 && i <= 13) return 4'(i - 6);
    case (i)
      28, 29, 30: return 4'd15;
      19: return 4'd14;
      16: return 4'd13;
      14, 15, 18: return 4'd12;
      22: return 4'd11;
      21: return 4'd10;
      17: return 4'd9;
      20: return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [31:0] mSysPend();
    return mMask[31] ? 32'd0 : (devIrq & ~mMask);
  endfunction

  function automatic logic [15:1] mHw(input int c);
    logic [15:1] v;
    logic [31:0] p;
    v = '0;
    p = mSysPend();
    if (mTgt != 2'(c)) return v;
    for (int i = 0; i < 32; i++)
      if (p[i] && mLvl(i) != 4'd0) v[mLvl(i)] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] mCpuPend(input int c);
    return {mSoft[c], 1'b0, mHw(c), 1'b0};
  endfunction

  function automatic logic [3:0] mCpuLevel(input int c);
    logic [15:1] v;
    logic [3:0] r;
    v = mSoft[c] | mHw(c);
    r = 0;
    for (int l = 1; l < 16; l++) if (v[l]) r = 4'(l);
    return r;
  endfunction

  function automatic logic [31:0] mRead(input int a);
    if (a < SYS) return (a % 4 == 0) ? mCpuPend(a / 4) : 32'd0;
    case (a - SYS)
      0: return mSysPend();
      1: return mMask;
      4: return {30'd0, mTgt};
      default: return 32'd0;
    endcase
  endfunction

  task automatic mWrite(input int a, input logic [31:0] d);
    if (a < SYS) begin
      if (a % 4 == 1) mSoft[a/4] = mSoft[a/4] & ~d[31:17];
      else if (a % 4 == 2) mSoft[a/4] = mSoft[a/4] | d[31:17];
    end else begin
      case (a - SYS)
        2: mMask = mMask & ~d;
        3: mMask = mMask | d;
        4: mTgt = d[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    busAddr = AW'(a); busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    mWrite(a, d);
  endtask

  task automatic readChk(input int a, input string tag);
    @(negedge clk);
    busAddr = AW'(a); busWe = 1'b0;
    #1;
    chkEq(tag, busRdata, mRead(a));
  endtask

  task automatic levelChk(input string tag);
    #1;
    for (int c = 0; c < NC; c++)
      chkEq(tag, 32'(cpuLevel[c*4 +: 4]), 32'(mCpuLevel(c)));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int c = 0; c < NC; c++) mSoft[c] = '0;
    mMask = '1; mTgt = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readChk(SYS + 1, "R1 mask");
    chkEq("R1 mask value", busRdata, 32'hFFFF_FFFF);
    readChk(SYS + 4, "R1 target");
    readChk(0, "R1 cpu0 pend");
    levelChk("R1 levels");

    // R2 set with bit 16 ignored
    doWrite(6, 32'h8003_0000);
    readChk(4, "R2 cpu1 pend");
    chkEq("R2 cpu1 value", busRdata, 32'h8002_0000);
    levelChk("R2 levels");

    // R3 clear, then zero write has no effect
    doWrite(5, 32'h8000_0000);
    readChk(4, "R3 cpu1 pend");
    doWrite(5, 32'h0000_0000);
    readChk(4, "R3 zero clear");
    chkEq("R3 cpu1 value", busRdata, 32'h0002_0000);
    levelChk("R3 levels");

    // R11 write-only and unused reads
    readChk(5, "R11 soft clr port");
    readChk(6, "R11 soft set port");
    readChk(7, "R11 cpu spare");
    readChk(SYS + 2, "R11 mask clr port");
    readChk(SYS + 3, "R11 mask set port");
    readChk(SYS + 5, "R11 unused");
    chkEq("R11 unused value", busRdata, 32'd0);

    // R5 / R6 / R4 masking
    @(negedge clk); devIrq = 32'h0008_0000;
    doWrite(SYS + 2, 32'h0008_0000);
    readChk(SYS + 1, "R4 mask after enable");
    readChk(SYS, "R5 mask-all pend");
    levelChk("R5 levels");
    doWrite(SYS + 2, 32'h8000_0000);
    readChk(SYS, "R6 sys pend");
    chkEq("R6 value", busRdata, 32'h0008_0000);
    readChk(0, "R8 cpu0 hw bits");
    levelChk("R10 timer level");

    // R7 / R8 retarget
    doWrite(SYS + 4, 32'hFFFF_FFFE);
    readChk(SYS + 4, "R7 target");
    chkEq("R7 target value", busRdata, 32'd2);
    readChk(0, "R8 cpu0 after move");
    readChk(8, "R8 cpu2 pend");
    levelChk("R8 levels");
    doWrite(SYS + 3, 32'h0008_0000);
    readChk(SYS + 1, "R4 mask after disable");
    levelChk("R4 disabled levels");

    // R9 level map per bit
    doWrite(SYS + 2, 32'hFFFF_FFFF);
    for (int b = 0; b < 32; b++) begin
      @(negedge clk); devIrq = 32'd1 << b;
      levelChk("R9 map");
    end

    // R10 soft vs routed priority, random mix
    for (int n = 0; n < 400; n++) begin
      int a;
      logic [31:0] d;
      @(negedge clk); devIrq = $urandom;
      a = $urandom_range(SYS + 7, 0);
      d = $urandom;
      if ($urandom_range(3, 0) != 0) doWrite(a, d);
      levelChk("R10 random");
      readChk($urandom_range(SYS + 7, 0), "R11 random read");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule